// File: doc/BRIEF.md
# Tagged Message Receive Matcher

This unit sits at the receiving end of a point-to-point message link. Each arriving message has a sender node number, a tag and one payload word. Messages that no receive has asked for yet are parked in a small store of fixed depth. A local consumer posts receive requests. Each request names a wanted sender and a wanted tag. Either field may be marked "don't care", and the two marks are independent of each other.

A request runs in one of two modes. In poll mode it completes with the oldest matching parked message, or it reports failure straight away. In wait mode it stays open until a match turns up. Only one wait-mode request can be open at a time. A message that satisfies an open request is handed over directly and never enters the store. The store never drops a message: once it is full, the link is held off through its ready signal.

Top module: `msg_match_rx`

## Requirements
- R1: After reset, `msg_ready_o` and `rcv_ready_o` are high, `rcv_done_o` and `rcv_fail_o` are low, and the store is empty.
- R2: A message is accepted when `msg_valid_i` and `msg_ready_o` are both high. `msg_ready_o` is low exactly while DEPTH messages are parked. A message offered while `msg_ready_o` is low is not taken and is not lost from the link.
- R3: A request is accepted on a cycle with `rcv_post_i` high and `rcv_ready_o` high. If a parked message has both the sender and the tag asked for, then on the next cycle `rcv_done_o` pulses high for one cycle. At the same time `rcv_src_o`, `rcv_tag_o` and `rcv_data_o` carry that message's sender, tag and payload.
- R4: `rcv_any_src_i`=1 ignores the sender field and `rcv_any_tag_i`=1 ignores the tag field. Each works alone or together with the other.
- R5: When several parked messages match, the one accepted earliest is returned.
- R6: A returned message is removed from the store. The relative order of the remaining messages is kept.
- R7: A poll-mode request (`rcv_wait_i`=0) with no match gives a one-cycle `rcv_fail_o` pulse on the next cycle and leaves the store unchanged.
- R8: A wait-mode request (`rcv_wait_i`=1) with no match drives `rcv_ready_o` low until it completes. It completes on the cycle a matching message is accepted, and `rcv_done_o` follows one cycle later. That message is not stored, while non-matching arrivals in the meantime are stored.
- R9: `rcv_post_i` is ignored while `rcv_ready_o` is low. Such a post gives no done, no fail and no change to the store.
- R10: If a parked message and a message arriving in the same cycle both match a request, the parked one is returned and the arriving one is stored.
- R11: `rcv_done_o` and `rcv_fail_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Arriving message present |
| msg_ready_o | output | 1 | Store can take a message |
| msg_src_i | input | SRC_W | Sender node of the arriving message |
| msg_tag_i | input | TAG_W | Tag of the arriving message |
| msg_data_i | input | DATA_W | Payload of the arriving message |
| rcv_post_i | input | 1 | Post a receive request |
| rcv_ready_o | output | 1 | No wait-mode request open; posts are taken |
| rcv_wait_i | input | 1 | 1 = wait mode, 0 = poll mode |
| rcv_src_i | input | SRC_W | Wanted sender |
| rcv_tag_i | input | TAG_W | Wanted tag |
| rcv_any_src_i | input | 1 | Sender is don't care |
| rcv_any_tag_i | input | 1 | Tag is don't care |
| rcv_done_o | output | 1 | One-cycle completion pulse |
| rcv_fail_o | output | 1 | One-cycle poll failure pulse |
| rcv_src_o | output | SRC_W | Sender of the returned message |
| rcv_tag_o | output | TAG_W | Tag of the returned message |
| rcv_data_o | output | DATA_W | Payload of the returned message |

## Verification
Random interleavings of arrivals and polls use a small range of senders and tags, so that hits, misses and multiple matches are all common. The four wildcard combinations show that each field comparison is gated on its own. Duplicate sender/tag pairs with different payloads show oldest-first order and compaction, because returning the wrong one of two equal keys changes the payload. Directed sequences fill the store to force back-pressure, hold a wait-mode request open across arrivals that do and do not match, and present a parked match together with an arriving match. The last case tells store-first priority apart from bypass.

// File: rtl/msg_match_pkg.sv
package msg_match_pkg;
  typedef enum logic {
    RCV_POLL = 1'b0,
    RCV_WAIT = 1'b1
  } rcv_mode_e;
endpackage

// File: rtl/msg_slot_store.sv
// Age-ordered store: slot 0 is the oldest; a pop compacts the slots above it.
module msg_slot_store #(
  parameter int DEPTH = 8,
  parameter int ENT_W = 24,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            push_i,
  input  logic [ENT_W-1:0]                push_ent_i,
  input  logic                            pop_i,
  input  logic [IDX_W-1:0]                pop_idx_i,
  output logic [DEPTH-1:0][ENT_W-1:0]     ent_o,
  output logic [CNT_W-1:0]                cnt_o,
  output logic                            full_o
);
  logic [ENT_W-1:0] ent_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] wr_idx;

  assign wr_idx = cnt_q - CNT_W'(pop_i);
  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CNT_W'(DEPTH));

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [ENT_W-1:0] upper;
    logic [ENT_W-1:0] nxt;
    if (i < DEPTH - 1) begin : g_mid
      assign upper = ent_q[i+1];
    end else begin : g_top
      assign upper = '0;
    end
    always_comb begin
      nxt = (pop_i && (IDX_W'(i) >= pop_idx_i)) ? upper : ent_q[i];
      if (push_i && (wr_idx == CNT_W'(i))) nxt = push_ent_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q[i] <= '0;
      else         ent_q[i] <= nxt;
    end
    assign ent_o[i] = ent_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
  end

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q < CNT_W'(DEPTH)) || pop_i);

  assert_pop_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (CNT_W'(pop_idx_i) < cnt_q));
endmodule

// File: rtl/msg_pick_oldest.sv
// Parallel sender/tag compare per slot, lowest (oldest) slot wins.
module msg_pick_oldest #(
  parameter int DEPTH  = 8,
  parameter int SRC_W  = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  parameter int ENT_W  = SRC_W + TAG_W + DATA_W,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][ENT_W-1:0] ent_i,
  input  logic [CNT_W-1:0]            cnt_i,
  input  logic [SRC_W-1:0]            want_src_i,
  input  logic [TAG_W-1:0]            want_tag_i,
  input  logic                        any_src_i,
  input  logic                        any_tag_i,
  output logic                        hit_o,
  output logic [IDX_W-1:0]            idx_o
);
  logic [DEPTH-1:0] hit_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic [SRC_W-1:0] e_src;
    logic [TAG_W-1:0] e_tag;
    assign e_src = ent_i[i][ENT_W-1 -: SRC_W];
    assign e_tag = ent_i[i][DATA_W+TAG_W-1 -: TAG_W];
    assign hit_vec[i] = (CNT_W'(i) < cnt_i)
                      && (any_src_i || (e_src == want_src_i))
                      && (any_tag_i || (e_tag == want_tag_i));
  end

  always_comb begin
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/msg_match_rx.sv
module msg_match_rx
  import msg_match_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SRC_W  = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msg_valid_i,
  output logic              msg_ready_o,
  input  logic [SRC_W-1:0]  msg_src_i,
  input  logic [TAG_W-1:0]  msg_tag_i,
  input  logic [DATA_W-1:0] msg_data_i,
  input  logic              rcv_post_i,
  output logic              rcv_ready_o,
  input  logic              rcv_wait_i,
  input  logic [SRC_W-1:0]  rcv_src_i,
  input  logic [TAG_W-1:0]  rcv_tag_i,
  input  logic              rcv_any_src_i,
  input  logic              rcv_any_tag_i,
  output logic              rcv_done_o,
  output logic              rcv_fail_o,
  output logic [SRC_W-1:0]  rcv_src_o,
  output logic [TAG_W-1:0]  rcv_tag_o,
  output logic [DATA_W-1:0] rcv_data_o
);
  localparam int ENT_W = SRC_W + TAG_W + DATA_W;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  // open wait-mode request
  logic             pend_q;
  logic [SRC_W-1:0] p_src_q;
  logic [TAG_W-1:0] p_tag_q;
  logic             p_any_src_q, p_any_tag_q;

  logic             post_acc, req_live, c_wait;
  logic [SRC_W-1:0] c_src;
  logic [TAG_W-1:0] c_tag;
  logic             c_any_src, c_any_tag;
  logic             arr_fire, arr_hit, buf_hit, take_buf, take_arr, complete, fail_now;
  logic [IDX_W-1:0] buf_idx;
  logic [ENT_W-1:0] in_ent, out_ent;
  logic [DEPTH-1:0][ENT_W-1:0] ent_all;
  logic [CNT_W-1:0] cnt;
  logic             full;

  logic             done_q, fail_q;
  logic [ENT_W-1:0] out_q;

  assign post_acc  = rcv_post_i && !pend_q;
  assign req_live  = pend_q || post_acc;
  assign c_src     = pend_q ? p_src_q     : rcv_src_i;
  assign c_tag     = pend_q ? p_tag_q     : rcv_tag_i;
  assign c_any_src = pend_q ? p_any_src_q : rcv_any_src_i;
  assign c_any_tag = pend_q ? p_any_tag_q : rcv_any_tag_i;
  assign c_wait    = rcv_mode_e'(rcv_wait_i) == RCV_WAIT;

  assign in_ent   = {msg_src_i, msg_tag_i, msg_data_i};
  assign arr_fire = msg_valid_i && msg_ready_o;
  assign arr_hit  = arr_fire && (c_any_src || (msg_src_i == c_src))
                             && (c_any_tag || (msg_tag_i == c_tag));

  // parked message is older than any arrival: it wins
  assign take_buf = req_live && buf_hit;
  assign take_arr = req_live && !buf_hit && arr_hit;
  assign complete = take_buf || take_arr;
  assign fail_now = post_acc && !c_wait && !complete;
  assign out_ent  = take_buf ? ent_all[buf_idx] : in_ent;

  msg_slot_store #(
    .DEPTH(DEPTH), .ENT_W(ENT_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (arr_fire && !take_arr),
    .push_ent_i (in_ent),
    .pop_i      (take_buf),
    .pop_idx_i  (buf_idx),
    .ent_o      (ent_all),
    .cnt_o      (cnt),
    .full_o     (full)
  );

  msg_pick_oldest #(
    .DEPTH(DEPTH), .SRC_W(SRC_W), .TAG_W(TAG_W), .DATA_W(DATA_W),
    .ENT_W(ENT_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_pick (
    .ent_i      (ent_all),
    .cnt_i      (cnt),
    .want_src_i (c_src),
    .want_tag_i (c_tag),
    .any_src_i  (c_any_src),
    .any_tag_i  (c_any_tag),
    .hit_o      (buf_hit),
    .idx_o      (buf_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      p_src_q     <= '0;
      p_tag_q     <= '0;
      p_any_src_q <= 1'b0;
      p_any_tag_q <= 1'b0;
    end else if (complete) begin
      pend_q <= 1'b0;
    end else if (post_acc && c_wait) begin
      pend_q      <= 1'b1;
      p_src_q     <= rcv_src_i;
      p_tag_q     <= rcv_tag_i;
      p_any_src_q <= rcv_any_src_i;
      p_any_tag_q <= rcv_any_tag_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      out_q  <= '0;
    end else begin
      done_q <= complete;
      fail_q <= fail_now;
      if (complete) out_q <= out_ent;
    end
  end

  assign msg_ready_o = !full;
  assign rcv_ready_o = !pend_q;
  assign rcv_done_o  = done_q;
  assign rcv_fail_o  = fail_q;
  assign rcv_src_o   = out_q[ENT_W-1 -: SRC_W];
  assign rcv_tag_o   = out_q[DATA_W+TAG_W-1 -: TAG_W];
  assign rcv_data_o  = out_q[DATA_W-1:0];

  assert_done_fail_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rcv_done_o && rcv_fail_o));

  assert_wait_no_parked_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !buf_hit);

  assert_wait_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rcv_ready_o && !(msg_valid_i && msg_ready_o)) |=> !rcv_ready_o && !rcv_done_o);

  assert_fail_only_after_post_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rcv_post_i && rcv_ready_o) |=> !rcv_fail_o);
endmodule

// File: tb/msg_match_rx_tb.sv
`timescale 1ns/1ps
module msg_match_rx_tb;
  localparam int DEPTH = 8, SRC_W = 4, TAG_W = 4, DATA_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic msg_valid = 0, rcv_post = 0, rcv_wait = 0, any_s = 0, any_t = 0;
  logic [SRC_W-1:0] msg_src = '0, want_src = '0;
  logic [TAG_W-1:0] msg_tag = '0, want_tag = '0;
  logic [DATA_W-1:0] msg_data = '0;
  logic msg_ready, rcv_ready, done, fail;
  logic [SRC_W-1:0] o_src;
  logic [TAG_W-1:0] o_tag;
  logic [DATA_W-1:0] o_data;

  int total = 0, bad = 0;

  typedef struct { int s; int t; int d; } ent_t;
  ent_t mq[$];

  always #10 clk = ~clk;

  msg_match_rx #(.DEPTH(DEPTH), .SRC_W(SRC_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .msg_valid_i(msg_valid), .msg_ready_o(msg_ready),
    .msg_src_i(msg_src), .msg_tag_i(msg_tag), .msg_data_i(msg_data),
    .rcv_post_i(rcv_post), .rcv_ready_o(rcv_ready), .rcv_wait_i(rcv_wait),
    .rcv_src_i(want_src), .rcv_tag_i(want_tag),
    .rcv_any_src_i(any_s), .rcv_any_tag_i(any_t),
    .rcv_done_o(done), .rcv_fail_o(fail),
    .rcv_src_o(o_src), .rcv_tag_o(o_tag), .rcv_data_o(o_data)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int find_match(int s, int t, bit as, bit at);
    for (int i = 0; i < mq.size(); i++)
      if ((as || mq[i].s == s) && (at || mq[i].t == t)) return i;
    return -1;
  endfunction

  // one arrival; stored when ready
  task automatic send(int s, int t, int d);
    bit rdy_exp = (mq.size() < DEPTH);
    check("R2 ready", int'(msg_ready), int'(rdy_exp));
    msg_valid = 1; msg_src = SRC_W'(s); msg_tag = TAG_W'(t); msg_data = DATA_W'(d);
    @(negedge clk);
    msg_valid = 0;
    if (rdy_exp) mq.push_back('{s, t, d});
  endtask

  // poll-mode receive checked against the model
  task automatic poll(int s, int t, bit as, bit at, string req);
    int k = find_match(s, t, as, at);
    rcv_post = 1; rcv_wait = 0; want_src = SRC_W'(s); want_tag = TAG_W'(t);
    any_s = as; any_t = at;
    @(negedge clk);
    rcv_post = 0; any_s = 0; any_t = 0;
    check({req, " done"}, int'(done), int'(k >= 0));
    check({req, " fail"}, int'(fail), int'(k < 0));
    if (k >= 0) begin
      check({req, " data"}, int'(o_data), mq[k].d);
      check({req, " src"}, int'(o_src), mq[k].s);
      check({req, " tag"}, int'(o_tag), mq[k].t);
      mq.delete(k);
    end
  endtask

  task automatic drain(string req);
    while (mq.size() > 0) poll(0, 0, 1, 1, req);
    poll(0, 0, 1, 1, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    repeat (3) @(negedge clk);
    check("R1 msg_ready", int'(msg_ready), 1);
    check("R1 rcv_ready", int'(rcv_ready), 1);
    check("R1 done", int'(done), 0);
    check("R1 fail", int'(fail), 0);
    rst_n = 1;
    @(negedge clk);
    poll(0, 0, 1, 1, "R1 empty");

    // R3 exact, R4 wildcards, R5 oldest of duplicates, R6 compaction
    send(1, 2, 100); send(3, 2, 101); send(1, 5, 102); send(1, 2, 103);
    poll(1, 2, 0, 0, "R3 exact");
    poll(1, 2, 0, 0, "R5 next of duplicate");
    poll(1, 2, 0, 0, "R6 removed");
    send(1, 2, 104);
    poll(0, 5, 1, 0, "R4 any src");
    poll(1, 9, 0, 1, "R4 any tag");
    poll(0, 0, 1, 1, "R4 any both");
    drain("R6 drain");

    // R7: failed poll keeps store intact
    send(2, 3, 200); send(4, 4, 201);
    poll(2, 4, 0, 0, "R7 miss");
    poll(0, 0, 1, 1, "R7 intact");
    poll(0, 0, 1, 1, "R7 intact");
    drain("R7 drain");

    // R2: fill, back-pressure, no loss
    for (int i = 0; i < DEPTH; i++) send(i % 4, i % 3, 300 + i);
    send(7, 7, 399);
    check("R2 full ready", int'(msg_ready), 0);
    poll(0, 0, 1, 1, "R2 pop");
    check("R2 ready back", int'(msg_ready), 1);
    drain("R2 drain");

    // R8: wait-mode request; R9 posts ignored while open
    send(5, 5, 400);
    rcv_post = 1; rcv_wait = 1; want_src = 6; want_tag = 1;
    @(negedge clk);
    rcv_post = 0; rcv_wait = 0;
    check("R8 waiting", int'(rcv_ready), 0);
    check("R8 no done", int'(done), 0);
    check("R8 no fail", int'(fail), 0);
    rcv_post = 1; want_src = 5; want_tag = 5;
    @(negedge clk);
    rcv_post = 0;
    check("R9 ignored done", int'(done), 0);
    check("R9 ignored fail", int'(fail), 0);
    send(6, 2, 401);
    check("R8 nonmatch no done", int'(done), 0);
    msg_valid = 1; msg_src = 6; msg_tag = 1; msg_data = 402;
    @(negedge clk);
    msg_valid = 0;
    check("R8 done", int'(done), 1);
    check("R8 data", int'(o_data), 402);
    check("R8 ready back", int'(rcv_ready), 1);
    poll(6, 1, 0, 0, "R8 not stored");
    poll(5, 5, 0, 0, "R9 store unchanged");
    drain("R8 drain");

    // R10: parked match beats simultaneous arriving match
    send(1, 1, 500);
    msg_valid = 1; msg_src = 1; msg_tag = 1; msg_data = 501;
    rcv_post = 1; rcv_wait = 0; want_src = 1; want_tag = 1;
    @(negedge clk);
    msg_valid = 0; rcv_post = 0;
    check("R10 done", int'(done), 1);
    check("R10 parked first", int'(o_data), 500);
    mq.delete(0); mq.push_back('{1, 1, 501});
    poll(1, 1, 0, 0, "R10 arrival stored");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int r = int'($urandom % 5);
      if (r < 2) send(int'($urandom % 4), int'($urandom % 4), int'($urandom % 65536));
      else begin
        bit as = ($urandom % 4) == 0;
        bit at = ($urandom % 4) == 0;
        poll(int'($urandom % 4), int'($urandom % 4), as, at, "R5 random");
      end
      check("R11 excl", int'(done && fail), 0);
    end
    drain("R6 final");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule